// File: doc/BRIEF.md
# Gated Down-Counter Timer

This block is a single 16-bit down-counting timer channel written from a CPU bus. Software stores a start value in a preload register and then writes an 8-bit control word. That word selects how the count starts, the active polarity of the gate input, whether timeout raises an interrupt, whether the count clock runs, and how the readable copy of the count is refreshed. The counter holds its start value and steps down once per count strobe while the gate is valid. When it reaches zero it drives the timer output low and may raise an active-low interrupt. On the next valid strobe it moves to FFFF and stays there until it is loaded again.

All logic runs on one system clock. A count strobe (`cnt_en`) marks the clock edges that act as the trailing edge of the count clock. The block has two start styles. In software start, a control write with the load bit set arms a preload, and the preload takes effect on the first strobe with the gate valid. In gate-triggered start, the channel is armed and then waits for the selected gate transition. After that transition the count runs on its own, whatever the gate level.

Top module: `gated_timer`

## Requirements
- R1: After reset, `tmr_out` is 0, `tmr_out_n` is 1, `irq_n` is 1, the counter and `hold_cnt` are 0, and every control field is 0.
- R2: Control word layout: bit 7 load, bit 6 hold, bit 5 run, bit 4 interrupt enable, bit 3 gate polarity, bits 2..0 mode. A control write with bit 7 set drives `tmr_out` low on the following cycle and arms a preload. On the first later strobe with the gate valid, the counter takes the preload value and `tmr_out` goes high.
- R3: With bit 3 at 1, a high gate level (or a rising gate edge) is valid. With bit 3 at 0, a low level (or a falling edge) is valid. With the wrong level, an armed preload stays pending.
- R4: A running count steps down by one on each strobe with the gate level valid. It holds its value while the gate is invalid or `cnt_en` is low.
- R5: When the count steps to zero, `tmr_out` goes low. The next counting strobe sets the count to FFFF, and the count then stays at FFFF until it is loaded again.
- R6: With bit 4 set, `irq_n` goes low on the cycle after the count reaches zero. It stays low until reset or any control write. With bit 4 clear, timeout leaves `irq_n` high.
- R7: With bit 5 at 0, no strobe loads or changes the counter. Counting resumes only after a control write sets bit 5 again.
- R8: With bit 6 at 0, `hold_cnt` follows the counter one cycle later. A control write with bit 6 set schedules a single capture of the counter on the next strobe, and `hold_cnt` then stays frozen until another such write.
- R9: A write to the preload register does not change a running count. The new value is used only by a later arming control write.
- R10: Mode field 000 keeps the current mode. 000 with bit 7 set re-arms the previous preload only if the preload register has not been written since the last arming write. Otherwise that write arms nothing.
- R11: Mode 011 with bit 7 at 0 drives `tmr_out` low and waits for the selected gate transition. The transition loads the preload, and the count then steps down on every strobe regardless of the gate level.
- R12: Mode 011 with bit 7 at 1 behaves exactly as the software-start timeout mode (001).
- R13: `tmr_out_n` is always the complement of `tmr_out`. A control write cycle takes precedence over a strobe in the same cycle: that strobe neither loads nor counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count strobe; marks a trailing count-clock edge |
| gate_in | input | 1 | Gate input, sampled on the system clock |
| jam_wr | input | 1 | Preload register write strobe |
| jam_data | input | 16 | Preload value |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_data | input | 8 | Control word |
| tmr_out | output | 1 | Timer output, high while a loaded count is running |
| tmr_out_n | output | 1 | Complement of the timer output |
| irq_n | output | 1 | Active-low interrupt |
| hold_cnt | output | 16 | Readable copy of the count |

## Verification
The assertions check on every cycle that the two timer outputs are complementary, that the counter never moves without a strobe while the run bit is set, and that a falling timer output only ever shows a count of zero or FFFF. They also check that a control write always releases the interrupt, that the interrupt never falls while it is disabled, and that the readable copy trails the counter in follow mode. Only the bench's scenarios can show the rest: which gate level or edge starts a load, when a preload applies, the sticky FFFF after timeout, the dirty-preload rule for mode 000, the gate-triggered start, and the one-shot refresh of the frozen copy.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam logic [2:0] MODE_KEEP    = 3'b000;
  localparam logic [2:0] MODE_TIMEOUT = 3'b001;
  localparam logic [2:0] MODE_HWSTART = 3'b011;

  typedef struct packed {
    logic       load_en;   // bit 7
    logic       hold_en;   // bit 6
    logic       run;       // bit 5
    logic       irq_en;    // bit 4
    logic       gate_hi;   // bit 3
    logic [2:0] mode;      // bits 2..0
  } ctrl_t;
endpackage

// File: rtl/gtmr_regs.sv
module gtmr_regs
  import gtmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic [7:0]    ctrl_data,
  input  logic          jam_wr,
  input  logic [CW-1:0] jam_data,
  output ctrl_t         ctrl_q,
  output logic [CW-1:0] jam_q,
  output logic          load_req,
  output logic          trig_req,
  output logic          refresh_req
);
  ctrl_t      wr_c;
  logic [2:0] mode_new;
  logic       keep_mode;
  logic       jam_dirty;

  always_comb begin
    wr_c        = ctrl_t'(ctrl_data);
    keep_mode   = (wr_c.mode == MODE_KEEP);
    mode_new    = keep_mode ? ctrl_q.mode : wr_c.mode;
    load_req    = ctrl_wr && wr_c.load_en && (!keep_mode || !jam_dirty);
    trig_req    = ctrl_wr && !wr_c.load_en && (mode_new == MODE_HWSTART);
    refresh_req = ctrl_wr && wr_c.hold_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      jam_q     <= '0;
      jam_dirty <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q      <= wr_c;
        ctrl_q.mode <= mode_new;
      end
      if (jam_wr) begin
        jam_q     <= jam_data;
        jam_dirty <= 1'b1;
      end else if (load_req) begin
        jam_dirty <= 1'b0;
      end
    end
  end

  // R10
  keep_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_data[2:0] == MODE_KEEP) |=> $stable(ctrl_q.mode));
endmodule

// File: rtl/gtmr_gate.sv
module gtmr_gate (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  input  logic gate_in,
  input  logic gate_hi,
  output logic lvl_ok,
  output logic edge_ok
);
  logic gate_prev;

  always_ff @(posedge clk) begin
    if (rst)         gate_prev <= 1'b0;
    else if (sample) gate_prev <= gate_in;
  end

  always_comb begin
    lvl_ok  = (gate_in == gate_hi);
    edge_ok = lvl_ok && (gate_prev != gate_hi);
  end
endmodule

// File: rtl/gtmr_count.sv
module gtmr_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ctrl_wr,
  input  logic          load_req,
  input  logic          trig_req,
  input  logic          irq_en,
  input  logic          lvl_ok,
  input  logic          edge_ok,
  input  logic [CW-1:0] jam_q,
  output logic [CW-1:0] cnt_q,
  output logic          tout_q,
  output logic          tout_n_q,
  output logic          irq_n_q
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] ZERO = '0;

  logic          pend_load, pend_trig, running, gated;
  logic          pend_load_d, pend_trig_d, running_d, gated_d;
  logic [CW-1:0] cnt_d;
  logic          tout_d, irq_n_d, fire;

  always_comb begin
    pend_load_d = pend_load;
    pend_trig_d = pend_trig;
    running_d   = running;
    gated_d     = gated;
    cnt_d       = cnt_q;
    tout_d      = tout_q;
    irq_n_d     = irq_n_q;
    fire        = 1'b0;
    if (ctrl_wr) begin
      irq_n_d = 1'b1;
      if (load_req) begin
        pend_load_d = 1'b1;
        pend_trig_d = 1'b0;
        running_d   = 1'b0;
        tout_d      = 1'b0;
      end else if (trig_req) begin
        pend_load_d = 1'b0;
        pend_trig_d = 1'b1;
        running_d   = 1'b0;
        tout_d      = 1'b0;
      end
    end else if (tick) begin
      if (pend_load && lvl_ok) begin
        cnt_d       = jam_q;
        tout_d      = 1'b1;
        running_d   = 1'b1;
        gated_d     = 1'b1;
        pend_load_d = 1'b0;
      end else if (pend_trig && edge_ok) begin
        cnt_d       = jam_q;
        tout_d      = 1'b1;
        running_d   = 1'b1;
        gated_d     = 1'b0;
        pend_trig_d = 1'b0;
      end else if (running && (lvl_ok || !gated)) begin
        if (cnt_q == ZERO) begin
          cnt_d     = '1;
          running_d = 1'b0;
          if (tout_q) begin
            tout_d = 1'b0;
            fire   = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - ONE;
          if (cnt_q == ONE) begin
            tout_d = 1'b0;
            fire   = 1'b1;
          end
        end
      end
    end
    if (fire && irq_en) irq_n_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      tout_q    <= 1'b0;
      tout_n_q  <= 1'b1;
      irq_n_q   <= 1'b1;
      pend_load <= 1'b0;
      pend_trig <= 1'b0;
      running   <= 1'b0;
      gated     <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      tout_q    <= tout_d;
      tout_n_q  <= ~tout_d;
      irq_n_q   <= irq_n_d;
      pend_load <= pend_load_d;
      pend_trig <= pend_trig_d;
      running   <= running_d;
      gated     <= gated_d;
    end
  end

  // R13
  out_compl_chk: assert property (@(posedge clk) disable iff (rst)
    tout_q != tout_n_q);
  // R7
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));
  // R5
  tout_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(tout_q) && !$past(ctrl_wr)) |-> (cnt_q == ZERO || cnt_q == '1));
  // R6
  irq_release_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> irq_n_q);
  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_en && irq_n_q) |=> irq_n_q);
endmodule

// File: rtl/gtmr_hold.sv
module gtmr_hold #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en,
  input  logic          follow,
  input  logic          refresh_req,
  input  logic [CW-1:0] cnt_q,
  output logic [CW-1:0] hold_q
);
  logic refresh_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q       <= '0;
      refresh_pend <= 1'b0;
    end else begin
      if (follow || (refresh_pend && cnt_en)) hold_q <= cnt_q;
      if (refresh_req)  refresh_pend <= 1'b1;
      else if (cnt_en)  refresh_pend <= 1'b0;
    end
  end

  // R8
  hold_follow_chk: assert property (@(posedge clk) disable iff (rst)
    follow |=> hold_q == $past(cnt_q));
endmodule

// File: rtl/gated_timer.sv
module gated_timer
  import gtmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en,
  input  logic          gate_in,
  input  logic          jam_wr,
  input  logic [CW-1:0] jam_data,
  input  logic          ctrl_wr,
  input  logic [7:0]    ctrl_data,
  output logic          tmr_out,
  output logic          tmr_out_n,
  output logic          irq_n,
  output logic [CW-1:0] hold_cnt
);
  ctrl_t         ctrl_q;
  logic [CW-1:0] jam_q, cnt_q;
  logic          load_req, trig_req, refresh_req, lvl_ok, edge_ok;

  gtmr_regs #(.CW(CW)) u_regs (
    .clk, .rst, .ctrl_wr, .ctrl_data, .jam_wr, .jam_data,
    .ctrl_q, .jam_q, .load_req, .trig_req, .refresh_req
  );

  gtmr_gate u_gate (
    .clk, .rst, .sample(cnt_en), .gate_in, .gate_hi(ctrl_q.gate_hi),
    .lvl_ok, .edge_ok
  );

  gtmr_count #(.CW(CW)) u_count (
    .clk, .rst, .tick(cnt_en && ctrl_q.run), .ctrl_wr, .load_req, .trig_req,
    .irq_en(ctrl_q.irq_en), .lvl_ok, .edge_ok, .jam_q,
    .cnt_q, .tout_q(tmr_out), .tout_n_q(tmr_out_n), .irq_n_q(irq_n)
  );

  gtmr_hold #(.CW(CW)) u_hold (
    .clk, .rst, .cnt_en, .follow(!ctrl_q.hold_en), .refresh_req,
    .cnt_q, .hold_q(hold_cnt)
  );
endmodule

// File: tb/gated_timer_bench.sv
module gated_timer_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0, rst = 1'b1, cnt_en = 1'b1, gate_in = 1'b0;
  logic        jam_wr = 1'b0, ctrl_wr = 1'b0;
  logic [15:0] jam_data = '0;
  logic [7:0]  ctrl_data = '0;
  logic        tmr_out, tmr_out_n, irq_n;
  logic [15:0] hold_cnt;

  int    checks = 0, errors = 0;
  bit    sparse = 0, done = 0;
  string tag = "R1";

  gated_timer u_gated_timer (
    .clk, .rst, .cnt_en, .gate_in, .jam_wr, .jam_data, .ctrl_wr, .ctrl_data,
    .tmr_out, .tmr_out_n, .irq_n, .hold_cnt
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) cnt_en <= sparse ? ~cnt_en : 1'b1;

  // behavioural reference
  int m_cnt, m_jam, m_hold, m_mode;
  bit m_tout, m_irq_n, m_ld, m_tr, m_run, m_gated, m_dirty, m_gprev, m_refresh;
  bit c_load, c_hold, c_run, c_ie, c_pol;

  always @(posedge clk) begin
    int nmode; bit lvl, edg, tick, ld, tr, fire;
    if (rst) begin
      m_cnt = 0; m_jam = 0; m_hold = 0; m_mode = 0; m_tout = 0; m_irq_n = 1;
      m_ld = 0; m_tr = 0; m_run = 0; m_gated = 0; m_dirty = 0; m_gprev = 0;
      m_refresh = 0; c_load = 0; c_hold = 0; c_run = 0; c_ie = 0; c_pol = 0;
    end else begin
      lvl  = (gate_in == c_pol);
      edg  = lvl && (m_gprev != c_pol);
      tick = cnt_en && c_run;
      fire = 0;
      if (!c_hold || (m_refresh && cnt_en)) m_hold = m_cnt;
      if (ctrl_wr && ctrl_data[6]) m_refresh = 1; else if (cnt_en) m_refresh = 0;
      if (cnt_en) m_gprev = gate_in;
      if (ctrl_wr) begin
        nmode = (ctrl_data[2:0] == 0) ? m_mode : int'(ctrl_data[2:0]);
        ld = ctrl_data[7] && (ctrl_data[2:0] != 0 || !m_dirty);
        tr = !ctrl_data[7] && nmode == 3;
        m_irq_n = 1;
        if (ld) begin m_ld = 1; m_tr = 0; m_run = 0; m_tout = 0; end
        else if (tr) begin m_ld = 0; m_tr = 1; m_run = 0; m_tout = 0; end
        if (jam_wr) m_dirty = 1; else if (ld) m_dirty = 0;
        {c_load, c_hold, c_run, c_ie, c_pol} = ctrl_data[7:3];
        m_mode = nmode;
      end else begin
        if (jam_wr) m_dirty = 1;
        if (tick) begin
          if (m_ld && lvl) begin
            m_cnt = m_jam; m_tout = 1; m_run = 1; m_gated = 1; m_ld = 0;
          end else if (m_tr && edg) begin
            m_cnt = m_jam; m_tout = 1; m_run = 1; m_gated = 0; m_tr = 0;
          end else if (m_run && (lvl || !m_gated)) begin
            if (m_cnt == 0) begin
              m_cnt = 65535; m_run = 0;
              if (m_tout) begin m_tout = 0; fire = 1; end
            end else begin
              m_cnt = m_cnt - 1;
              if (m_cnt == 0) begin m_tout = 0; fire = 1; end
            end
          end
        end
        if (fire && c_ie) m_irq_n = 0;
      end
      if (jam_wr) m_jam = int'(jam_data);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (tmr_out !== m_tout || tmr_out_n !== !m_tout || irq_n !== m_irq_n ||
          hold_cnt !== 16'(m_hold)) begin
        errors++;
        $display("FAIL %s (R13 per-cycle) out=%b/%b irq_n=%b hold=%h exp out=%b/%b irq_n=%b hold=%h",
                 tag, tmr_out, tmr_out_n, irq_n, hold_cnt, m_tout, !m_tout, m_irq_n, 16'(m_hold));
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wjam(input logic [15:0] v);
    @(negedge clk); jam_wr = 1; jam_data = v;
    @(negedge clk); jam_wr = 0;
  endtask

  task automatic wctrl(input logic [7:0] v);
    @(negedge clk); ctrl_wr = 1; ctrl_data = v;
    @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] h;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 out", tmr_out, 0); chk("R1 out_n", tmr_out_n, 1);
    chk("R1 irq_n", irq_n, 1); chk("R1 hold", hold_cnt, 0);

    tag = "R2/R5";
    wjam(16'd5); gate_in = 1; wctrl(8'hB9); idle(12);
    chk("R5 count sticks at FFFF", hold_cnt, 16'hFFFF);
    chk("R5 out low", tmr_out, 0); chk("R6 irq low", irq_n, 0);
    idle(4); chk("R5 still FFFF", hold_cnt, 16'hFFFF);

    tag = "R6";
    wctrl(8'h39); chk("R6 ctrl write releases irq", irq_n, 1);

    tag = "R3";
    wjam(16'd4); gate_in = 1; wctrl(8'hA1); idle(5);
    chk("R3 wrong level keeps load pending", hold_cnt, 16'hFFFF);
    chk("R3 out low while pending", tmr_out, 0);
    gate_in = 0; idle(2);
    chk("R3 low level loads", hold_cnt, 4);
    tag = "R4";
    gate_in = 1; idle(4);
    chk("R4 stall while gate invalid", hold_cnt, 3); chk("R4 out high", tmr_out, 1);
    gate_in = 0; idle(10);
    chk("R6 masked irq stays high", irq_n, 1); chk("R5 timeout", hold_cnt, 16'hFFFF);

    tag = "R7";
    wjam(16'd20); gate_in = 1; wctrl(8'hB9); idle(5);
    wctrl(8'h19); idle(3); h = hold_cnt; idle(5);
    chk("R7 stopped count stays", hold_cnt, h);
    wctrl(8'h39); idle(2);
    chk("R7 resumes", int'(hold_cnt < h), 1);
    tag = "R9";
    wjam(16'd100); idle(30);
    chk("R9 preload write ignored by running count", hold_cnt, 16'hFFFF);
    tag = "R2";
    gate_in = 0; wctrl(8'hB9);
    chk("R2 arm drives out low", tmr_out, 0);
    idle(3); chk("R2 no load without valid gate", tmr_out, 0);
    gate_in = 1; idle(1); chk("R2 load drives out high", tmr_out, 1);
    idle(110);

    tag = "R10";
    wjam(16'd6); wctrl(8'hB8); idle(5);
    chk("R10 dirty preload: mode-keep write arms nothing", tmr_out, 0);
    chk("R10 count untouched", hold_cnt, 16'hFFFF);
    wctrl(8'hB9); idle(10);
    wctrl(8'hB8); idle(2);
    chk("R10 clean mode-keep reload out", tmr_out, 1);
    chk("R10 reloaded value", hold_cnt, 6);
    idle(10);

    tag = "R11";
    gate_in = 1; wjam(16'd3); wctrl(8'h3B); idle(4);
    chk("R11 waits for edge", tmr_out, 0);
    gate_in = 0; idle(2); gate_in = 1; idle(1);
    chk("R11 edge starts", tmr_out, 1);
    gate_in = 0; idle(8);
    chk("R11 counts regardless of gate", hold_cnt, 16'hFFFF);
    chk("R11 irq", irq_n, 0);

    tag = "R12";
    gate_in = 1; wctrl(8'hBB); idle(2);
    chk("R12 immediate start", tmr_out, 1);
    idle(8); chk("R12 timeout", tmr_out, 0);

    tag = "R8";
    wjam(16'd30); wctrl(8'hF9); idle(5);
    h = hold_cnt; idle(4);
    chk("R8 frozen copy", hold_cnt, h);
    wctrl(8'h79); idle(2);
    chk("R8 refresh changes copy", int'(hold_cnt != h), 1);
    h = hold_cnt; idle(3); chk("R8 frozen after refresh", hold_cnt, h);
    wctrl(8'h39); idle(40);

    tag = "R4 sparse";
    sparse = 1; wjam(16'd7); wctrl(8'hB9); idle(30); sparse = 0;
    idle(2);
    chk("R4 sparse strobes timeout", hold_cnt, 16'hFFFF);
    chk("R13 complement", int'(tmr_out_n), int'(!tmr_out));

    finish_run();
  end
endmodule